// File: doc/BRIEF.md
# Edge-Triggered Timestamp Capture Unit

This block timestamps transitions on up to four slow external inputs. A free-running timestamp counter advances once per prescaled tick while the unit is globally enabled. Each input passes through a two-flop synchronizer and an edge detector. When the edge chosen for a channel appears, the counter value is latched into that channel's capture register and the channel's sticky interrupt status bit is set.

Software sees the unit through a 32-bit register interface. Reads return data one cycle after the request. To measure a pulse train, software arms a channel for the rising edge. After each capture it inverts the edge selection by XOR-ing the 2-bit code with 3, which swaps rising and falling. It then subtracts successive captured timestamps to obtain the high time and the period.

Top module: `cap_unit`

## Requirements
- R1: After reset every readable register (capture 0x10+4n, edge select 0x30+4n, control 0x50, interrupt enable 0x54, status 0x58) reads 0 and `irq` is 0.
- R2: The edge register of channel n at 0x30+4n holds a 2-bit code in bits 1:0 and reads back what was written. Code 0 captures nothing, 1 captures rising edges only, 2 captures falling edges only, and 3 captures both.
- R3: The control register at 0x50 holds the prescale value P in bits 8:4. The timestamp advances once every P+1 clock cycles. Two captures on a channel whose input edges lie G cycles apart, with G a multiple of P+1, differ by G/(P+1). Capture registers sit at 0x10+4n.
- R4: Bit 10 of 0x50 is the global enable, and only bits 10 and 8:4 read back. While the enable bit is 0, no capture register or status bit changes, and the timestamp does not advance.
- R5: A capture on channel n sets status bit n+1 at 0x58. That bit stays set until it is acknowledged.
- R6: A write to 0x5C clears each status bit whose matching bit in bits 4:1 of the written data is 1. Other status bits are left alone. Writing 0x1FF clears all of them.
- R7: When a capture and an acknowledge of the same channel land in the same cycle, the status bit ends up set.
- R8: `irq` is 1 exactly when some status bit and its interrupt enable bit (0x54, bits 4:1) are both 1. It follows register writes and captures in the same cycle as the status register does.
- R9: An edge on one channel changes neither the capture register nor the status bit of any other channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | AW | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| cap_in | input | NCH | Asynchronous capture inputs |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the cycle where a capture and an acknowledge of the same channel coincide. The bench reaches it by counting the synchronizer latency exactly. It changes an input on a falling clock edge and waits two rising edges. It then issues an all-ones acknowledge write, so the write lands on the same edge as the capture. A second channel whose status was set earlier must be cleared by that write. The timestamp freeze is checked in a similar way. The bench disables the unit for a known number of edges between two captures and expects the captured difference to shrink by exactly that count.

// File: rtl/cap_pkg.sv
package cap_pkg;
  typedef enum logic [1:0] {
    EDGE_OFF  = 2'd0,
    EDGE_RISE = 2'd1,
    EDGE_FALL = 2'd2,
    EDGE_ANY  = 2'd3
  } edge_sel_e;

  localparam logic [31:0] OFS_CAP  = 32'h10;
  localparam logic [31:0] OFS_EDGE = 32'h30;
  localparam logic [31:0] OFS_CTRL = 32'h50;
  localparam logic [31:0] OFS_IEN  = 32'h54;
  localparam logic [31:0] OFS_ISTS = 32'h58;
  localparam logic [31:0] OFS_IACK = 32'h5C;
  localparam logic [31:0] BANK_MASK = 32'hFFFF_FFF3;

  localparam int CTRL_RUN_BIT = 10;
  localparam int CTRL_DIV_LSB = 4;
  localparam int CTRL_DIV_MAX = 5;
endpackage

// File: rtl/cap_timebase.sv
module cap_timebase #(
  parameter int TS_W = 32,
  parameter int PS_W = 5
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            run,
  input  logic [PS_W-1:0] div,
  output logic [TS_W-1:0] stamp
);
  logic [PS_W-1:0] pcnt;
  logic            tick;

  assign tick = (pcnt >= div);

  always_ff @(posedge clk) begin
    if (rst) begin
      pcnt  <= '0;
      stamp <= '0;
    end else if (!run) begin
      pcnt  <= '0;
    end else if (tick) begin
      pcnt  <= '0;
      stamp <= stamp + 1'b1;
    end else begin
      pcnt  <= pcnt + 1'b1;
    end
  end

  // R4
  stamp_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(run) |-> stamp == $past(stamp));

  // R3
  stamp_step_chk: assert property (@(posedge clk) disable iff (rst)
    stamp != $past(stamp) |-> stamp == $past(stamp) + 1'b1);
endmodule

// File: rtl/cap_channel.sv
module cap_channel #(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            din,
  input  logic            arm,
  input  logic [1:0]      edge_sel,
  input  logic [TS_W-1:0] stamp,
  output logic            hit,
  output logic [TS_W-1:0] value
);
  logic [2:0] sh;
  logic       rise;
  logic       fall;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  assign rise = sh[1] & ~sh[2];
  assign fall = ~sh[1] & sh[2];
  assign hit  = arm & ((edge_sel[0] & rise) | (edge_sel[1] & fall));

  always_ff @(posedge clk) begin
    if (rst)      value <= '0;
    else if (hit) value <= stamp;
  end

  // R2
  value_only_on_hit_chk: assert property (@(posedge clk) disable iff (rst)
    value != $past(value) |-> $past(hit));
endmodule

// File: rtl/cap_unit.sv
module cap_unit
  import cap_pkg::*;
#(
  parameter int NCH  = 4,
  parameter int TS_W = 32,
  parameter int PS_W = 5,
  parameter int AW   = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic           rd_en,
  input  logic [AW-1:0]  addr,
  input  logic [31:0]    wdata,
  output logic [31:0]    rdata,
  input  logic [NCH-1:0] cap_in,
  output logic           irq
);
  localparam int IDX_W = 2;

  logic [31:0]      a32;
  logic [IDX_W-1:0] ridx;
  logic             hit_cap, hit_edge, hit_ctrl, hit_ien, hit_ists, hit_iack;

  logic             run_q;
  logic [PS_W-1:0]  div_q;
  logic [1:0]       sel_q [NCH];
  logic [NCH-1:0]   ien_q, ien_nxt;
  logic [NCH-1:0]   sts_q, sts_nxt;
  logic [NCH-1:0]   ack_mask;
  logic [NCH-1:0]   hit_v;
  logic [TS_W-1:0]  stamp;
  logic [TS_W-1:0]  cval [NCH];
  logic [31:0]      rd_mux;

  assign a32      = 32'(addr);
  assign ridx     = a32[3:2];
  assign hit_cap  = (a32 & BANK_MASK) == OFS_CAP;
  assign hit_edge = (a32 & BANK_MASK) == OFS_EDGE;
  assign hit_ctrl = a32 == OFS_CTRL;
  assign hit_ien  = a32 == OFS_IEN;
  assign hit_ists = a32 == OFS_ISTS;
  assign hit_iack = a32 == OFS_IACK;

  cap_timebase #(.TS_W(TS_W), .PS_W(PS_W)) u_tb (
    .clk(clk), .rst(rst), .run(run_q), .div(div_q), .stamp(stamp)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cap_channel #(.TS_W(TS_W)) u_ch (
      .clk(clk), .rst(rst), .din(cap_in[g]), .arm(run_q),
      .edge_sel(sel_q[g]), .stamp(stamp), .hit(hit_v[g]), .value(cval[g])
    );

    always_ff @(posedge clk) begin
      if (rst)
        sel_q[g] <= EDGE_OFF;
      else if (wr_en && hit_edge && int'(ridx) == g)
        sel_q[g] <= wdata[1:0];
    end

    // R5 R7
    capture_wins_chk: assert property (@(posedge clk) disable iff (rst)
      $past(hit_v[g]) |-> sts_q[g]);

    // R5
    sts_set_cause_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(sts_q[g]) |-> $past(hit_v[g]));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      div_q <= '0;
    end else if (wr_en && hit_ctrl) begin
      run_q <= wdata[CTRL_RUN_BIT];
      div_q <= wdata[CTRL_DIV_LSB +: PS_W];
    end
  end

  assign ack_mask = (wr_en && hit_iack) ? wdata[NCH:1] : '0;
  assign sts_nxt  = (sts_q & ~ack_mask) | hit_v;
  assign ien_nxt  = (wr_en && hit_ien) ? wdata[NCH:1] : ien_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sts_q <= '0;
      ien_q <= '0;
      irq   <= 1'b0;
    end else begin
      sts_q <= sts_nxt;
      ien_q <= ien_nxt;
      irq   <= |(sts_nxt & ien_nxt);
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_cap && int'(ridx) < NCH)
      rd_mux[TS_W-1:0] = cval[ridx];
    else if (hit_edge && int'(ridx) < NCH)
      rd_mux[1:0] = sel_q[ridx];
    else if (hit_ctrl) begin
      rd_mux[CTRL_RUN_BIT] = run_q;
      rd_mux[CTRL_DIV_LSB +: PS_W] = div_q;
    end else if (hit_ien)
      rd_mux[NCH:1] = ien_q;
    else if (hit_ists)
      rd_mux[NCH:1] = sts_q;
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R8
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == |(sts_q & ien_q));

  initial begin
    if (NCH < 1 || NCH > 4 || PS_W > CTRL_DIV_MAX || TS_W > 32 || AW < 8 || AW > 31)
      $error("cap_unit: parameter out of range");
  end
endmodule

// File: tb/cap_unit_bench.sv
module cap_unit_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  cap_in = '0;
  logic        irq;
  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  cap_unit u_cap_unit (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .cap_in(cap_in), .irq(irq)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    d = rdata; rd_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v0, v1, v;
    int ps [4] = '{0, 1, 3, 6};
    step(3);
    rst = 1'b0;
    step(1);

    // R1 reset state
    for (int n = 0; n < 4; n++) begin
      rd(8'(8'h10 + 4*n), v); chk("R1 cap", v, 0);
      rd(8'(8'h30 + 4*n), v); chk("R1 edge", v, 0);
    end
    rd(8'h50, v); chk("R1 ctrl", v, 0);
    rd(8'h54, v); chk("R1 ien", v, 0);
    rd(8'h58, v); chk("R1 sts", v, 0);
    chk("R1 irq", 32'(irq), 0);

    // R4 readback masking
    wr(8'h50, 32'hFFFF_FFFF); rd(8'h50, v); chk("R4 ctrl mask", v, 32'h5F0);

    // R3 sweep of prescale x channel
    foreach (ps[k]) begin
      for (int ch = 0; ch < 4; ch++) begin
        int g;
        g = (ps[k] + 1) * (5 + ch);
        wr(8'(8'h30 + 4*ch), 3);
        wr(8'h50, 32'h400 | 32'(ps[k] << 4));
        cap_in[ch] = 1'b1; step(3); rd(8'(8'h10 + 4*ch), v0);
        step(g - 4);
        cap_in[ch] = 1'b0; step(3); rd(8'(8'h10 + 4*ch), v1);
        chk("R3 delta", v1 - v0, 32'(g / (ps[k] + 1)));
        rd(8'h58, v); chk("R5 R9 sts one bit", v, 32'(1 << (ch + 1)));
        wr(8'h5C, 32'(1 << (ch + 1)));
        rd(8'h58, v); chk("R6 ack own bit", v, 0);
        wr(8'(8'h30 + 4*ch), 0);
      end
    end

    // R2 edge code sweep on channel 2, prescale 0
    wr(8'h50, 32'h400);
    for (int m = 0; m < 4; m++) begin
      wr(8'h38, 32'(m)); rd(8'h38, v); chk("R2 edge readback", v, 32'(m));
      rd(8'h18, v0);
      cap_in[2] = 1'b1; step(4);
      rd(8'h58, v); chk("R2 rise sts", v, (m & 1) ? 32'h8 : 32'h0);
      rd(8'h18, v1); chk("R2 rise cap moved", 32'(v1 != v0), 32'(m & 1));
      wr(8'h5C, 32'h1FF);
      cap_in[2] = 1'b0; step(4);
      rd(8'h58, v); chk("R2 fall sts", v, (m & 2) ? 32'h8 : 32'h0);
      wr(8'h5C, 32'h1FF);
    end
    wr(8'h38, 0);

    // R6 partial and full acknowledge
    wr(8'h34, 1); wr(8'h38, 1);
    cap_in[1] = 1'b1; cap_in[2] = 1'b1; step(4);
    rd(8'h58, v); chk("R5 two bits", v, 32'hC);
    wr(8'h5C, 32'h4); rd(8'h58, v); chk("R6 partial ack", v, 32'h8);
    wr(8'h5C, 32'h1FF); rd(8'h58, v); chk("R6 full ack", v, 0);
    cap_in[1] = 1'b0; cap_in[2] = 1'b0; step(4);
    wr(8'h38, 0);

    // R7 capture and acknowledge on the same edge
    wr(8'h30, 1);
    cap_in[1] = 1'b1; step(4);
    rd(8'h58, v); chk("R7 setup", v, 32'h4);
    cap_in[0] = 1'b1; step(2);
    wr(8'h5C, 32'h1FF);
    rd(8'h58, v); chk("R7 capture wins", v, 32'h2);
    cap_in[0] = 1'b0; cap_in[1] = 1'b0; step(4);
    wr(8'h5C, 32'h1FF);

    // R8 interrupt gating
    wr(8'h54, 32'h4); rd(8'h54, v); chk("R8 ien readback", v, 32'h4);
    chk("R8 irq idle", 32'(irq), 0);
    cap_in[1] = 1'b1; step(3);
    chk("R8 irq on capture", 32'(irq), 1);
    wr(8'h54, 32'h8); chk("R8 irq masked", 32'(irq), 0);
    wr(8'h54, 32'h4); chk("R8 irq unmasked", 32'(irq), 1);
    wr(8'h5C, 32'h4); chk("R8 irq after ack", 32'(irq), 0);
    cap_in[1] = 1'b0; step(4);
    wr(8'h34, 0); wr(8'h30, 0); wr(8'h54, 0);

    // R4 disabled unit ignores edges
    wr(8'h3C, 3); wr(8'h50, 0);
    rd(8'h1C, v0);
    cap_in[3] = 1'b1; step(4); cap_in[3] = 1'b0; step(4);
    rd(8'h58, v); chk("R4 no sts when off", v, 0);
    rd(8'h1C, v1); chk("R4 cap held when off", v1, v0);

    // R4 timestamp frozen while disabled
    wr(8'h50, 32'h400);
    cap_in[3] = 1'b1; step(3); rd(8'h1C, v0);
    step(2); wr(8'h50, 0); step(7); wr(8'h50, 32'h400); step(5);
    cap_in[3] = 1'b0; step(3); rd(8'h1C, v1);
    chk("R4 frozen delta", v1 - v0, 12);
    rd(8'h58, v); chk("R9 only ch3", v, 32'h10);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule